// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to eight interrupt requests from peripherals and hands the processor one of them at a time. Each request line is edge-triggered. A rising edge on a line marks that line as pending. The controller then keeps a single interrupt output asserted for as long as a pending line outranks every line that is currently being serviced. When the processor pulses the acknowledge input, the controller takes the best eligible line. It clears that line's pending flag, marks the line as in service, and in the next cycle presents an 8-bit vector. The vector is the programmed 5-bit base followed by the 3-bit line number.

Service can nest. While a line is in service, only lines of strictly higher priority may interrupt. A request on the same line or on a lower-priority line waits in the pending set. An end-of-interrupt pulse retires the highest-priority line that is in service, and this re-opens the lower-priority lines.

Two units can be chained to reach fifteen sources. A slave unit's interrupt output feeds line 2 of a master unit, and the master's cascade-mode input is held high. When line 2 wins an acknowledge at the master, the master produces no vector of its own. Instead it raises its slave-select output in that same cycle. That output serves as the slave's acknowledge, so the slave supplies the vector one cycle later.

The vector leaves on a valid-only stream. The vector valid signal is high for exactly one cycle and there is no ready signal: the acknowledge pulse is the consumer's request, so back-pressure is never applied and the processor must capture the vector in the cycle in which it is valid.

Top module: `vic_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, the interrupt output, vector valid and slave select are all low.
- R2: A request line becomes pending only on a low-to-high transition, and the interrupt output rises in the cycle after that edge. A line that stays high after its request has been acknowledged raises no new request.
- R3: When several pending lines are eligible, the line with the lowest index wins. Line 0 has the highest priority and line 7 the lowest.
- R4: An acknowledge with an eligible winner produces a vector on the following cycle. Vector valid is high for exactly one cycle, and the vector data is {base[4:0], line[2:0]}, with the base sampled in the acknowledge cycle.
- R5: An acknowledge clears the winning line's pending flag and sets its in-service flag. If nothing else is eligible, the interrupt output falls in the following cycle.
- R6: A line is eligible only if its index is strictly lower than that of the highest-priority in-service line. A pending request of equal or lower priority keeps the interrupt output low, and a strictly higher one raises it even while another line is in service.
- R7: An end-of-interrupt pulse clears only the highest-priority in-service flag. The interrupt output is then re-evaluated in the following cycle.
- R8: With cascade mode on, a win by line 2 at acknowledge produces no vector from this unit and asserts slave select combinationally in the acknowledge cycle. The chained slave then gives the vector {slave base, slave line}.
- R9: With cascade mode off, line 2 behaves as an ordinary line and yields its own vector.
- R10: An acknowledge while no line is eligible produces no vector and changes neither the pending nor the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Peripheral request lines, rising-edge sensitive |
| vec_base | input | 5 | Upper five bits of every vector |
| casc_master | input | 1 | 1: line 2 is the link to a slave unit |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector data valid, one cycle |
| vec_data | output | 8 | Vector {base, line} |
| slave_sel | output | 1 | Acknowledge for the chained slave |

## Verification
The hardest situation to reach is a two-deep nesting. A lower-priority line must stay pending while masked, be passed over by a preempting line, and then be granted only after two end-of-interrupt pulses have unwound the nesting. The stimulus holds line 3 and line 6 high together and acknowledges line 3. It then preempts with line 1 and re-pulses line 3 while line 3 is still in service. Finally it retires the nesting one level at a time, checking the interrupt output after every pulse. The cascade path requires the slave's registered interrupt output to propagate into the master's edge detector, so the bench waits two cycles before it acknowledges. It then checks that the vector comes from the slave and that no vector comes from the master.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VIC_LINES     = 8;
  localparam int unsigned VIC_BASE_W    = 5;
  localparam int unsigned VIC_CASC_LINE = 2;
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  for (genvar g = 0; g < N; g++) begin : g_grant
    if (g == 0) begin : g_top
      assign grant[g] = req[g];
    end else begin : g_rest
      assign grant[g] = req[g] & ~(|req[g-1:0]);
    end
  end

  assign any = |req;
endmodule

// File: rtl/vic_req_latch.sv
module vic_req_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] pend_nxt
);
  logic [N-1:0] line_q;
  logic [N-1:0] rise;

  assign rise     = lines & ~line_q;
  assign pend_nxt = (pend & ~clr) | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend   <= '0;
    end else begin
      line_q <= lines;
      pend   <= pend_nxt;
    end
  end

  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));

  p_clr_hits_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |-> ((clr & pend) == clr));

  p_no_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(rise)) == '0));
endmodule

// File: rtl/vic_isr_track.sv
module vic_isr_track #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_oh,
  input  logic         eoi,
  output logic [N-1:0] isr,
  output logic [N-1:0] mask,
  output logic [N-1:0] mask_nxt
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] top_cur;
  logic [N-1:0] top_nxt;
  logic         any_cur;
  logic         any_nxt;
  logic [N-1:0] isr_nxt;

  vic_prio_pick #(.N(N)) u_pick_cur (.req(isr),     .grant(top_cur), .any(any_cur));
  vic_prio_pick #(.N(N)) u_pick_nxt (.req(isr_nxt), .grant(top_nxt), .any(any_nxt));

  assign isr_nxt  = (isr & ~(eoi ? top_cur : '0)) | set_oh;
  assign mask     = any_cur ? (top_cur - ONE) : '1;
  assign mask_nxt = any_nxt ? (top_nxt - ONE) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_nxt;
  end

  p_eoi_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (|isr) && !(|set_oh)) |=> ($countones(isr) == $past($countones(isr)) - 1));

  p_set_outranks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_oh) |-> ((set_oh & isr) == '0));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
  parameter int unsigned LINES     = vic_pkg::VIC_LINES,
  parameter int unsigned BASE_W    = vic_pkg::VIC_BASE_W,
  parameter int unsigned CASC_LINE = vic_pkg::VIC_CASC_LINE,
  localparam int unsigned IW       = $clog2(LINES),
  localparam int unsigned VW       = BASE_W + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic [BASE_W-1:0] vec_base,
  input  logic              casc_master,
  input  logic              ack,
  input  logic              eoi,
  output logic              int_out,
  output logic              vec_valid,
  output logic [VW-1:0]     vec_data,
  output logic              slave_sel
);
  logic [LINES-1:0] pend, pend_nxt;
  logic [LINES-1:0] isr, mask, mask_nxt;
  logic [LINES-1:0] allowed, grant_oh, clr;
  logic             grant_any, take, casc_win;
  logic [IW-1:0]    grant_idx;

  vic_req_latch #(.N(LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .clr(clr),
    .pend(pend), .pend_nxt(pend_nxt)
  );

  vic_isr_track #(.N(LINES)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_oh(clr), .eoi(eoi),
    .isr(isr), .mask(mask), .mask_nxt(mask_nxt)
  );

  assign allowed = pend & mask;

  vic_prio_pick #(.N(LINES)) u_pick (.req(allowed), .grant(grant_oh), .any(grant_any));

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (grant_oh[i]) grant_idx = IW'(i);
    end
  end

  assign take      = ack & grant_any;
  assign casc_win  = casc_master & grant_oh[CASC_LINE];
  assign slave_sel = take & casc_win;
  assign clr       = take ? grant_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      int_out   <= |(pend_nxt & mask_nxt);
      vec_valid <= take & ~casc_win;
      if (take & ~casc_win) vec_data <= {vec_base, grant_idx};
    end
  end

  p_vec_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));

  p_vec_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_data[VW-1:IW] == $past(vec_base)));

  p_casc_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slave_sel |=> !vec_valid);

  p_sel_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_sel |-> casc_master);
endmodule

// File: tb/vic_ctrl_tb_top.sv
module vic_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] b_irq = '0;
  logic [7:0] s_irq = '0;
  logic [4:0] m_base = 5'h08;
  logic [4:0] s_base = 5'h0E;
  logic ack = 1'b0, eoi_m = 1'b0, eoi_s = 1'b0;

  logic m_int, m_vv, m_sel, s_int, s_vv, s_sel;
  logic [7:0] m_vd, s_vd, m_irq;

  assign m_irq = {b_irq[7:3], s_int, b_irq[1:0]};

  vic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(m_irq), .vec_base(m_base), .casc_master(1'b1),
    .ack(ack), .eoi(eoi_m), .int_out(m_int), .vec_valid(m_vv), .vec_data(m_vd),
    .slave_sel(m_sel)
  );

  vic_ctrl slv_i (
    .clk(clk), .rst_n(rst_n), .irq_in(s_irq), .vec_base(s_base), .casc_master(1'b0),
    .ack(m_sel), .eoi(eoi_s), .int_out(s_int), .vec_valid(s_vv), .vec_data(s_vd),
    .slave_sel(s_sel)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: pops one expected vector per valid beat.
  always @(negedge clk) begin
    #1;
    if (rst_n && (m_vv || s_vv)) begin
      logic [7:0] got;
      got = m_vv ? m_vd : s_vd;
      if (m_vv && s_vv) chk(1'b0, "R8 both units gave a vector", 2, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected vector", int'(got), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R4 vector value", int'(got), int'(e));
      end
    end
  end

  // Driver: push expectation, pulse ack, then check the outcome.
  task automatic do_ack(input bit exp_vec, input logic [7:0] ev, input bit exp_sel, input string req);
    if (exp_vec) exp_q.push_back(ev);
    ack = 1'b1;
    #1;
    chk(m_sel == exp_sel, req, int'(m_sel), int'(exp_sel));
    @(negedge clk);
    ack = 1'b0;
    #2;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    if (!exp_vec) chk(!m_vv && !s_vv, req, int'(m_vv | s_vv), 0);
  endtask

  task automatic pulse_eoi(input bit m, input bit s);
    @(negedge clk);
    eoi_m = m;
    eoi_s = s;
    @(negedge clk);
    eoi_m = 1'b0;
    eoi_s = 1'b0;
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(2);
    #1;
    chk(!m_int && !m_vv && !m_sel, "R1 in reset", int'({m_int, m_vv, m_sel}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    #1;
    chk(!m_int && !m_vv && !m_sel && !s_int, "R1 after reset", int'({m_int, m_vv, m_sel, s_int}), 0);

    // Lines 3 and 6 together: 3 wins.
    @(negedge clk);
    b_irq[3] = 1'b1;
    b_irq[6] = 1'b1;
    @(negedge clk);
    #1;
    chk(m_int, "R2 edge raises int", int'(m_int), 1);
    do_ack(1'b1, 8'h43, 1'b0, "R3 lowest index wins");
    chk(!m_int, "R6 lower line masked", int'(m_int), 0);

    // Spurious acknowledge: nothing eligible.
    do_ack(1'b0, 8'h00, 1'b0, "R10 ack with nothing eligible");
    tick(1);
    #1;
    chk(!m_int, "R10 state unchanged", int'(m_int), 0);

    // Preemption by line 1.
    b_irq[1] = 1'b1;
    @(negedge clk);
    #1;
    chk(m_int, "R6 higher line preempts", int'(m_int), 1);
    do_ack(1'b1, 8'h41, 1'b0, "R6 preempt vector");

    pulse_eoi(1'b1, 1'b0);
    chk(!m_int, "R7 eoi clears only line 1", int'(m_int), 0);

    // Re-request on line 3 while it is in service.
    @(negedge clk);
    b_irq[3] = 1'b0;
    @(negedge clk);
    b_irq[3] = 1'b1;
    tick(2);
    #1;
    chk(!m_int, "R6 equal priority held", int'(m_int), 0);

    pulse_eoi(1'b1, 1'b0);
    chk(m_int, "R7 eoi reopens lower lines", int'(m_int), 1);
    do_ack(1'b1, 8'h43, 1'b0, "R3 re-pended line 3 beats 6");
    chk(!m_int, "R6 line 6 masked again", int'(m_int), 0);
    pulse_eoi(1'b1, 1'b0);
    chk(m_int, "R7 line 6 eligible", int'(m_int), 1);
    do_ack(1'b1, 8'h46, 1'b0, "R3 line 6 last");
    pulse_eoi(1'b1, 1'b0);
    tick(3);
    #1;
    chk(!m_int, "R2 held levels raise nothing", int'(m_int), 0);
    @(negedge clk);
    b_irq = '0;

    // Single request: pending cleared by ack.
    @(negedge clk);
    b_irq[0] = 1'b1;
    @(negedge clk);
    #1;
    do_ack(1'b1, 8'h40, 1'b0, "R5 single ack");
    chk(!m_int, "R5 int falls after ack", int'(m_int), 0);
    pulse_eoi(1'b1, 1'b0);
    tick(1);
    #1;
    chk(!m_int, "R5 pending was cleared", int'(m_int), 0);
    b_irq[0] = 1'b0;

    // Base change takes effect.
    @(negedge clk);
    m_base = 5'h1F;
    b_irq[7] = 1'b1;
    @(negedge clk);
    #1;
    do_ack(1'b1, 8'hFF, 1'b0, "R4 base and line 7");
    pulse_eoi(1'b1, 1'b0);
    b_irq[7] = 1'b0;

    // Cascade through line 2.
    @(negedge clk);
    s_irq[4] = 1'b1;
    tick(2);
    #1;
    chk(m_int, "R8 slave request reaches master", int'(m_int), 1);
    do_ack(1'b1, 8'h74, 1'b1, "R8 cascade ack");
    chk(!s_sel, "R9 slave does not cascade", int'(s_sel), 0);
    pulse_eoi(1'b1, 1'b1);
    s_irq[4] = 1'b0;

    // Slave line 2 is ordinary there.
    @(negedge clk);
    s_irq[2] = 1'b1;
    tick(2);
    #1;
    chk(m_int, "R9 slave line 2 request", int'(m_int), 1);
    do_ack(1'b1, 8'h72, 1'b1, "R9 slave line 2 vector");
    pulse_eoi(1'b1, 1'b1);
    s_irq[2] = 1'b0;
    tick(3);

    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule